// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Core

This block is a small 32-bit processor that completes one instruction in every clock cycle. On each rising edge it fetches a word from an internal program memory at the current program counter. It decodes the word, reads two operands from a 32-entry register file, computes a result and writes it back. In the same edge it may update a word of internal data memory, and it moves the program counter to the next, branch, jump or register-held address.

Both memories are word arrays indexed by byte address bits `[AW+1:2]`, with `AW = log2(MEM_WORDS)`. Higher address bits are ignored, so larger addresses wrap onto the array. Before a program runs, a testbench or loader writes words into either memory through a load port while reset is held. A debug port shows the program counter and returns the contents of any register. This lets a harness observe architectural state without touching the internals.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0. No register or data memory write takes place during such a cycle. The register file is not cleared.
- R2: Instructions are 32 bits, in three formats whose fields run from the most significant bit down. Register format: op[31:26], rs[25:21], rt[20:16], rd[15:11], shift[10:6], func[5:0]. Immediate format: op, rs, rt, imm[15:0]. Jump format: op, target[25:0]. Any instruction that does not change control flow advances the program counter by 4.
- R3: With op 0x00, func 0x20 writes rs+rt to rd, func 0x22 writes rs-rt, func 0x24 writes rs AND rt, and func 0x25 writes rs OR rt. Func 0x2A writes 1 to rd when rs is less than rt as signed numbers, and 0 otherwise.
- R4: With op 0x00, func 0x00 writes rt shifted left by the shift field to rd. Func 0x02 writes rt shifted right by the shift field to rd, filling with zeros.
- R5: Register 0 always reads as zero, and writes aimed at it are discarded.
- R6: Op 0x08 writes rs plus the sign-extended 16-bit immediate to rt.
- R7: Op 0x23 loads the data word at address rs + sign-extended immediate into rt. Op 0x2B stores rt to that address. The data memory is indexed by address bits [AW+1:2].
- R8: Op 0x04 (equal) and op 0x05 (not equal) compare rs with rt. When the condition holds, the next program counter is PC+4 plus the sign-extended immediate shifted left by 2. When it does not hold, the next program counter is PC+4.
- R9: Op 0x02 jumps to {PC[31:28], target, 2'b00}. Op 0x03 makes the same jump and also writes PC+4 to register 31.
- R10: Op 0x00 with func 0x08 loads the program counter from rs with its two low bits cleared, so the program counter is always word aligned.
- R11: An unrecognised op, or an unrecognised func under op 0x00, writes no register and no memory, and advances the program counter by 4.
- R12: `dbg_pc` shows the current program counter. `dbg_rdata` shows, one cycle later, the register selected by `dbg_sel`.
- R13: When `load_en` is high at a rising edge, `load_data` is written to word `load_addr` of the data memory if `load_dmem` is 1, or of the program memory if it is 0. A load-port write to data memory takes priority over a store in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load port write strobe |
| load_dmem | input | 1 | Load port target: 1 data memory, 0 program memory |
| load_addr | input | AW | Load port word index |
| load_data | input | 32 | Load port write data |
| dbg_sel | input | 5 | Register number for debug read |
| dbg_pc | output | 32 | Current program counter |
| dbg_rdata | output | 32 | Registered contents of the selected register |

## Verification
The hardest situations to reach from the ports are flows where one instruction's effect only becomes visible through a later one. Examples are a store checked by a load from a wrapped high address, a link register checked after a subroutine return, and a skipped instruction whose target register must keep an earlier value. The bench reaches these with a hand-laid program that jumps to a far address and returns. It calls a subroutine, runs a counted backward loop, and executes undefined encodings between marker writes. A sweep then reloads a short program for sixteen operand pairs and shift amounts, with the operands preloaded into data memory, and reads every result through the debug port.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_J    = 6'h02;
  localparam logic [5:0] OP_JAL  = 6'h03;
  localparam logic [5:0] OP_BEQ  = 6'h04;
  localparam logic [5:0] OP_BNE  = 6'h05;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;

  localparam logic [5:0] FN_SLL = 6'h00;
  localparam logic [5:0] FN_SRL = 6'h02;
  localparam logic [5:0] FN_JR  = 6'h08;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_SLL, ALU_SRL
  } alu_op_e;

  typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dst_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_PC4} wb_e;

  typedef struct packed {
    logic    reg_we;
    dst_e    dst;
    wb_e     wb;
    logic    use_imm;
    logic    mem_we;
    logic    br_eq;
    logic    br_ne;
    logic    jump;
    logic    jump_reg;
    alu_op_e op;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctl
);
  logic [5:0] opc;
  logic [5:0] fn;
  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    ctl     = '0;
    ctl.dst = DST_RD;
    ctl.wb  = WB_ALU;
    ctl.op  = ALU_ADD;
    case (opc)
      OP_REG: begin
        case (fn)
          FN_ADD: begin ctl.reg_we = 1'b1; ctl.op = ALU_ADD; end
          FN_SUB: begin ctl.reg_we = 1'b1; ctl.op = ALU_SUB; end
          FN_AND: begin ctl.reg_we = 1'b1; ctl.op = ALU_AND; end
          FN_OR:  begin ctl.reg_we = 1'b1; ctl.op = ALU_OR;  end
          FN_SLT: begin ctl.reg_we = 1'b1; ctl.op = ALU_SLT; end
          FN_SLL: begin ctl.reg_we = 1'b1; ctl.op = ALU_SLL; end
          FN_SRL: begin ctl.reg_we = 1'b1; ctl.op = ALU_SRL; end
          FN_JR:  ctl.jump_reg = 1'b1;
          default: ;
        endcase
      end
      OP_ADDI: begin
        ctl.reg_we = 1'b1; ctl.dst = DST_RT; ctl.use_imm = 1'b1;
      end
      OP_LW: begin
        ctl.reg_we = 1'b1; ctl.dst = DST_RT; ctl.use_imm = 1'b1; ctl.wb = WB_MEM;
      end
      OP_SW: begin
        ctl.use_imm = 1'b1; ctl.mem_we = 1'b1;
      end
      OP_BEQ: ctl.br_eq = 1'b1;
      OP_BNE: ctl.br_ne = 1'b1;
      OP_J:   ctl.jump = 1'b1;
      OP_JAL: begin
        ctl.jump = 1'b1; ctl.reg_we = 1'b1; ctl.dst = DST_LINK; ctl.wb = WB_PC4;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [SHW-1:0] shamt,
  output logic [W-1:0]   y
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLL: y = b << shamt;
      ALU_SRL: y = b >> shamt;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd2,
  input  logic [AW-1:0] ra3,
  output logic [W-1:0]  rd3
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  // registered debug read port
  always_ff @(posedge clk) begin
    rd3 <= (ra3 == '0) ? '0 : regs[ra3];
  end

  p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
    (we && waddr != '0) |=> (regs[$past(waddr)] == $past(wdata)));

  p_zero_debug_r5: assert property (@(posedge clk) disable iff (rst)
    (ra3 == '0) |=> (rd3 == '0));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int MEM_WORDS = 256,
  parameter int NREGS     = 32,
  localparam int AW  = $clog2(MEM_WORDS),
  localparam int RAW = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_en,
  input  logic            load_dmem,
  input  logic [AW-1:0]   load_addr,
  input  logic [XLEN-1:0] load_data,
  input  logic [RAW-1:0]  dbg_sel,
  output logic [XLEN-1:0] dbg_pc,
  output logic [XLEN-1:0] dbg_rdata
);
  logic [XLEN-1:0] imem [MEM_WORDS];
  logic [XLEN-1:0] dmem [MEM_WORDS];

  logic [XLEN-1:0] pc_q, pc_nx, pc4, br_tgt, j_tgt;
  logic [31:0]     instr;
  ctrl_t           ctl;
  logic [XLEN-1:0] rs_val, rt_val, sext, alu_b, alu_y, ld_val, rf_wdata;
  logic [RAW-1:0]  rf_waddr;
  logic [AW-1:0]   d_idx;
  logic            take, flow_chg;

  assign instr = imem[pc_q[AW+1:2]];
  assign sext  = {{(XLEN-16){instr[15]}}, instr[15:0]};

  sc_decode u_dec (.instr(instr), .ctl(ctl));

  sc_regfile #(.W(XLEN), .N(NREGS)) u_rf (
    .clk(clk), .rst(rst),
    .we(ctl.reg_we && !rst), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra1(instr[25:21]), .rd1(rs_val),
    .ra2(instr[20:16]), .rd2(rt_val),
    .ra3(dbg_sel), .rd3(dbg_rdata)
  );

  assign alu_b = ctl.use_imm ? sext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .op(ctl.op), .a(rs_val), .b(alu_b), .shamt(instr[10:6]), .y(alu_y)
  );

  // memories
  assign d_idx  = alu_y[AW+1:2];
  assign ld_val = dmem[d_idx];

  always_ff @(posedge clk) begin
    if (load_en && !load_dmem) imem[load_addr] <= load_data;
  end

  always_ff @(posedge clk) begin
    if (load_en && load_dmem)       dmem[load_addr] <= load_data;
    else if (ctl.mem_we && !rst)    dmem[d_idx]     <= rt_val;
  end

  // write-back
  always_comb begin
    case (ctl.dst)
      DST_RT:   rf_waddr = instr[20:16];
      DST_LINK: rf_waddr = RAW'(31);
      default:  rf_waddr = instr[15:11];
    endcase
    case (ctl.wb)
      WB_MEM:  rf_wdata = ld_val;
      WB_PC4:  rf_wdata = pc4;
      default: rf_wdata = alu_y;
    endcase
  end

  // next program counter
  assign pc4      = pc_q + XLEN'(4);
  assign br_tgt   = pc4 + {sext[XLEN-3:0], 2'b00};
  assign j_tgt    = {pc_q[31:28], instr[25:0], 2'b00};
  assign take     = (ctl.br_eq && rs_val == rt_val) || (ctl.br_ne && rs_val != rt_val);
  assign flow_chg = take || ctl.jump || ctl.jump_reg;

  always_comb begin
    if (ctl.jump_reg)  pc_nx = {rs_val[XLEN-1:2], 2'b00};
    else if (ctl.jump) pc_nx = j_tgt;
    else if (take)     pc_nx = br_tgt;
    else               pc_nx = pc4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nx;
  end

  assign dbg_pc = pc_q;

  p_pc_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc_q == '0));

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(flow_chg)) |-> (pc_q == $past(pc_q) + XLEN'(4)));

  p_branch_tgt_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl.br_eq && rs_val == rt_val) |=> (pc_q == $past(pc_q) + XLEN'(4) + ($past(sext) << 2)));

  p_pc_aligned_r10: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);

  p_store_lands_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl.mem_we && !load_en) |=> (dmem[$past(d_idx)] == $past(rt_val)));
endmodule

// File: tb/sc_core_test.sv
module sc_core_test;
  localparam int MW = 256;
  localparam int AW = $clog2(MW);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_en = 1'b0;
  logic          load_dmem = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [31:0]   load_data = '0;
  logic [4:0]    dbg_sel = '0;
  logic [31:0]   dbg_pc, dbg_rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  sc_core #(.MEM_WORDS(MW), .NREGS(32)) uut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_dmem(load_dmem),
    .load_addr(load_addr), .load_data(load_data), .dbg_sel(dbg_sel),
    .dbg_pc(dbg_pc), .dbg_rdata(dbg_rdata)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int op, int tgt);
    return {6'(op), 26'(tgt)};
  endfunction

  task automatic put(input bit to_dmem, input int byte_addr, input logic [31:0] w);
    @(negedge clk);
    load_en   = 1'b1;
    load_dmem = to_dmem;
    load_addr = AW'((byte_addr >> 2) & (MW - 1));
    load_data = w;
    @(negedge clk);
    load_en   = 1'b0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_reg(input string req, input int r, input logic [31:0] exp);
    @(negedge clk);
    dbg_sel = 5'(r);
    @(negedge clk);
    check(req, dbg_rdata, exp);
  endtask

  initial begin
    logic [31:0] a, b;
    int sh;
    // ---------------- program 1 (loaded during reset) ----------------
    put(0, 0,   enc_i(8, 0, 1, 36));
    put(0, 4,   enc_i(8, 0, 2, 30000));
    put(0, 8,   enc_r(2, 2, 2, 0, 'h20));
    put(0, 12,  enc_i(8, 0, 4, 57));
    put(0, 16,  enc_i('h2B, 2, 4, 'h4E20));     // store 57 at byte 80000
    put(0, 20,  enc_j(2, 2500));                // go to 10000
    put(0, 10000, 32'h8C434E20);                // load word into r3
    put(0, 10004, enc_r(3, 1, 5, 0, 'h20));
    put(0, 10008, enc_j(2, 6));
    put(0, 24,  enc_r(1, 4, 6, 0, 'h22));
    put(0, 28,  enc_r(2, 4, 7, 0, 'h24));
    put(0, 32,  enc_r(2, 4, 8, 0, 'h25));
    put(0, 36,  enc_r(6, 1, 9, 0, 'h2A));
    put(0, 40,  enc_r(1, 6, 10, 0, 'h2A));
    put(0, 44,  enc_r(0, 4, 11, 4, 'h00));
    put(0, 48,  enc_r(0, 6, 12, 28, 'h02));
    put(0, 52,  enc_i(8, 0, 13, -5));
    put(0, 56,  enc_i(8, 0, 0, 99));
    put(0, 60,  enc_r(0, 1, 14, 0, 'h20));
    put(0, 64,  enc_i(8, 0, 16, 7));
    put(0, 68,  enc_i(4, 1, 4, 1));             // not taken
    put(0, 72,  enc_i(8, 0, 15, 1));
    put(0, 76,  enc_i(5, 1, 4, 1));             // taken, skips next
    put(0, 80,  enc_i(8, 0, 16, 1));
    put(0, 84,  enc_i(8, 0, 18, 5));
    put(0, 88,  enc_i(8, 0, 17, 0));
    put(0, 92,  enc_i(8, 17, 17, 1));
    put(0, 96,  enc_i(5, 17, 18, -2));          // backward loop
    put(0, 100, enc_j(3, 40));                  // call to byte 160
    put(0, 104, enc_i(8, 0, 20, 22));
    put(0, 108, enc_i(8, 0, 21, 3));
    put(0, 112, enc_r(1, 1, 21, 0, 'h3F));      // undefined func
    put(0, 116, {6'h3F, 5'd1, 5'd21, 16'h1234}); // undefined op
    put(0, 120, enc_i(8, 0, 23, 9));
    put(0, 124, enc_i(8, 0, 22, 138));
    put(0, 128, enc_r(22, 0, 0, 0, 'h08));      // register jump to 136
    put(0, 132, enc_i(8, 0, 23, 1));
    put(0, 136, enc_i(8, 0, 24, 44));
    put(0, 140, enc_i(4, 0, 0, -1));            // halt
    put(0, 160, enc_i(8, 0, 19, 11));
    put(0, 164, enc_r(31, 0, 0, 0, 'h08));

    @(negedge clk);
    check("R1 pc after reset", dbg_pc, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 sequential step", dbg_pc, 32'd4);
    repeat (5) @(negedge clk);
    check("R9 jump target", dbg_pc, 32'd10000);
    repeat (200) @(negedge clk);
    check("R8 halt loop pc", dbg_pc, 32'd140);

    check_reg("R7 load after store", 3, 32'd57);
    check_reg("R3 add", 5, 32'd93);
    check_reg("R3 add doubling", 2, 32'd60000);
    check_reg("R3 sub", 6, 32'(36 - 57));
    check_reg("R3 and", 7, 32'(60000 & 57));
    check_reg("R3 or", 8, 32'(60000 | 57));
    check_reg("R3 slt true", 9, 32'd1);
    check_reg("R3 slt false", 10, 32'd0);
    check_reg("R4 sll", 11, 32'(57 << 4));
    check_reg("R4 srl zero fill", 12, 32'hF);
    check_reg("R6 negative immediate", 13, 32'hFFFFFFFB);
    check_reg("R5 r0 stays zero", 0, 32'd0);
    check_reg("R5 r0 reads zero", 14, 32'd36);
    check_reg("R8 not taken falls through", 15, 32'd1);
    check_reg("R8 taken skips", 16, 32'd7);
    check_reg("R8 backward loop", 17, 32'd5);
    check_reg("R9 subroutine ran", 19, 32'd11);
    check_reg("R9 link value", 31, 32'd104);
    check_reg("R10 return landed", 20, 32'd22);
    check_reg("R11 undefined codes inert", 21, 32'd3);
    check_reg("R10 jump skipped", 23, 32'd9);
    check_reg("R10 low bits cleared", 24, 32'd44);
    check_reg("R12 debug read", 22, 32'd138);

    // ---------------- sweep: operands from data memory ----------------
    for (int i = 0; i < 16; i++) begin
      a  = 32'(i) * 32'h9E3779B9 + 32'h01234567;
      b  = (i % 4 == 0) ? a : (32'(i) * 32'h7F4A7C15) ^ 32'h80000001;
      sh = (i * 7) % 32;
      rst = 1'b1;
      put(1, 0, a);                              // R13 data preload
      put(1, 4, b);
      put(0, 0,  enc_i('h23, 0, 1, 0));
      put(0, 4,  enc_i('h23, 0, 2, 4));
      put(0, 8,  enc_r(1, 2, 3, 0, 'h20));
      put(0, 12, enc_r(1, 2, 4, 0, 'h22));
      put(0, 16, enc_r(1, 2, 5, 0, 'h24));
      put(0, 20, enc_r(1, 2, 6, 0, 'h25));
      put(0, 24, enc_r(1, 2, 7, 0, 'h2A));
      put(0, 28, enc_r(2, 1, 8, 0, 'h2A));
      put(0, 32, enc_r(0, 1, 9, sh, 'h00));
      put(0, 36, enc_r(0, 1, 10, sh, 'h02));
      put(0, 40, enc_i(8, 0, 11, 0));
      put(0, 44, enc_i(4, 1, 2, 1));
      put(0, 48, enc_i(8, 0, 11, 1));
      put(0, 52, enc_i(4, 0, 0, -1));
      @(negedge clk);
      rst = 1'b0;
      repeat (30) @(negedge clk);
      check("R13 load port program", dbg_pc, 32'd52);
      check_reg("R3 sweep add", 3, a + b);
      check_reg("R3 sweep sub", 4, a - b);
      check_reg("R3 sweep and", 5, a & b);
      check_reg("R3 sweep or", 6, a | b);
      check_reg("R3 sweep slt ab", 7, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
      check_reg("R3 sweep slt ba", 8, ($signed(b) < $signed(a)) ? 32'd1 : 32'd0);
      check_reg("R4 sweep sll", 9, a << sh);
      check_reg("R4 sweep srl", 10, a >> sh);
      check_reg("R8 sweep equal branch", 11, (a == b) ? 32'd0 : 32'd1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule